// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt RAM

This block is a synchronous two-port memory in which either port may read or write any word on any cycle. The two highest addresses double as mailboxes. Port A's mailbox is the all-ones address minus one, and port B's mailbox is the all-ones address. When one port writes into the other port's mailbox, it raises that partner's active-low interrupt. The partner drops the interrupt again by accessing its own mailbox with enable and output enable both active. Both mailbox words remain ordinary storage, so the message byte that was written can be read back.

Each port has its own active-low busy input. While a port's busy input is low, any interrupt set or clear that this port's access would cause is suppressed. The memory access itself still takes place.

The block uses one clock and an asynchronous active-low reset whose release is synchronised inside the block. Read data is registered. An interrupt output changes on the clock edge that samples the access causing the change.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is applied, and after it is released until the first access, both interrupt outputs are high and both read data outputs are zero.
- R2: A port writes `wdata` to `addr` on an edge where `ce`=1 and `we`=1. A port reads on an edge where `ce`=1, `oe`=1 and `we`=0, and the word appears on `rdata` after that edge. When neither condition holds, `rdata` keeps its value.
- R3: Port B writing the address 2^AW-2 raises `a_irq_n` (drives it low) after that edge.
- R4: `a_irq_n` returns high after an edge where port A has `ce`=1 and `oe`=1 at address 2^AW-2, whatever the level of `a_we`.
- R5: Port A writing the address 2^AW-1 drives `b_irq_n` low after that edge.
- R6: `b_irq_n` returns high after an edge where port B has `ce`=1 and `oe`=1 at address 2^AW-1.
- R7: Both mailbox words store the written byte and return it on a later read, like any other word.
- R8: A set is ignored while the writing port's `busy_n` is 0. A clear is ignored while the clearing port's `busy_n` is 0.
- R9: When a set and a clear of the same interrupt fall on the same edge, the interrupt ends up asserted (low).
- R10: When both ports write the same address on one edge, port A's data is kept. A read and a write to the same address on one edge return the old word.
- R11: Writes to any other address leave both interrupts unchanged. A port writing its own mailbox does not change its own interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ce | input | 1 | Port A enable |
| a_we | input | 1 | Port A write (1) / read (0) |
| a_oe | input | 1 | Port A output enable |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_busy_n | input | 1 | Port A busy, low suppresses its interrupt effects |
| a_rdata | output | DW | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_ce | input | 1 | Port B enable |
| b_we | input | 1 | Port B write (1) / read (0) |
| b_oe | input | 1 | Port B output enable |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_busy_n | input | 1 | Port B busy, low suppresses its interrupt effects |
| b_rdata | output | DW | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The set of an interrupt and its clear can fall on the same edge: one port writes the partner's mailbox while the partner accesses that same mailbox. This case is provoked directly, and it also arises often in random traffic that is biased toward the top addresses. In both cases the outcome is judged against a bench model in which the set takes priority. Busy suppression is mixed into the same collisions, so that a gated set meeting a live clear, and a live set meeting a gated clear, are both checked.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    FL_KEEP = 2'd0,
    FL_SET  = 2'd1,
    FL_CLR  = 2'd2
  } flag_act_e;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [1:0]    wr_en,
  input  logic [1:0]    rd_en,
  input  logic [AW-1:0] addr [2],
  input  logic [DW-1:0] wdata [2],
  output logic [DW-1:0] rdata [2]
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // index 1 (port B) first, so port A's write lands last on a shared word
  always_ff @(posedge clk) begin
    if (wr_en[1]) mem[addr[1]] <= wdata[1];
    if (wr_en[0]) mem[addr[0]] <= wdata[0];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DW-1:0] rd_d;
    logic [DW-1:0] rd_q;

    always_comb begin
      rd_d = rd_q;
      if (rd_en[p]) rd_d = mem[addr[p]];
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)       rd_q <= '0;
      else if (rd_en[p]) rd_q <= rd_d;
    end

    assign rdata[p] = rd_q;
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
  import mbox_pkg::*;
(
  input  logic clk,
  input  logic srst_n,
  input  logic set_req,
  input  logic set_ok,
  input  logic clr_req,
  input  logic clr_ok,
  output logic irq_n
);
  flag_act_e act;
  logic      flag_d;
  logic      flag_q;

  always_comb begin
    act = FL_KEEP;
    if (set_req && set_ok)      act = FL_SET;
    else if (clr_req && clr_ok) act = FL_CLR;
    flag_d = (act == FL_SET);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)              flag_q <= 1'b0;
    else if (act != FL_KEEP)  flag_q <= flag_d;
  end

  assign irq_n = ~flag_q;
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_ce,
  input  logic          a_we,
  input  logic          a_oe,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_busy_n,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq_n,
  input  logic          b_ce,
  input  logic          b_we,
  input  logic          b_oe,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_busy_n,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq_n
);
  localparam logic [AW-1:0] BOX_B = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_A = BOX_B - 1'b1;

  logic          srst_n;
  logic [1:0]    ce, we, oe, busy_n, wr_en, rd_en, hit_own, hit_peer;
  logic [1:0]    set_req, clr_req, set_ok, clr_ok, irq_n;
  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [AW-1:0] own_box [2];

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  assign ce     = {b_ce, a_ce};
  assign we     = {b_we, a_we};
  assign oe     = {b_oe, a_oe};
  assign busy_n = {b_busy_n, a_busy_n};
  assign addr[0]  = a_addr;
  assign addr[1]  = b_addr;
  assign wdata[0] = a_wdata;
  assign wdata[1] = b_wdata;
  assign own_box[0] = BOX_A;
  assign own_box[1] = BOX_B;

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign wr_en[p]    = ce[p] & we[p];
    assign rd_en[p]    = ce[p] & oe[p] & ~we[p];
    assign hit_own[p]  = (addr[p] == own_box[p]);
    assign hit_peer[p] = (addr[p] == own_box[1-p]);
    // flag p is set by the other port writing p's box
    assign set_req[p]  = wr_en[1-p] & hit_peer[1-p];
    assign set_ok[p]   = busy_n[1-p];
    assign clr_req[p]  = ce[p] & oe[p] & hit_own[p];
    assign clr_ok[p]   = busy_n[p];

    mbox_flag u_flag (
      .clk(clk), .srst_n(srst_n),
      .set_req(set_req[p]), .set_ok(set_ok[p]),
      .clr_req(clr_req[p]), .clr_ok(clr_ok[p]),
      .irq_n(irq_n[p])
    );
  end

  mbox_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .srst_n(srst_n),
    .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  assign a_rdata = rdata[0];
  assign b_rdata = rdata[1];
  assign a_irq_n = irq_n[0];
  assign b_irq_n = irq_n[1];
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          srst_n,
  input logic          a_ce,
  input logic          a_we,
  input logic          a_oe,
  input logic [AW-1:0] a_addr,
  input logic          a_busy_n,
  input logic          a_irq_n,
  input logic          b_ce,
  input logic          b_we,
  input logic          b_oe,
  input logic [AW-1:0] b_addr,
  input logic          b_busy_n,
  input logic          b_irq_n
);
  localparam logic [AW-1:0] BOX_B = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_A = BOX_B - 1'b1;

  logic a_set, a_clr, b_set, b_clr;
  assign a_set = b_ce && b_we && (b_addr == BOX_A) && b_busy_n;
  assign a_clr = a_ce && a_oe && (a_addr == BOX_A) && a_busy_n;
  assign b_set = a_ce && a_we && (a_addr == BOX_B) && a_busy_n;
  assign b_clr = b_ce && b_oe && (b_addr == BOX_B) && b_busy_n;

  p_set_a_r3: assert property (@(posedge clk) disable iff (!srst_n)
    a_set |=> !a_irq_n);
  p_clr_a_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (a_clr && !a_set) |=> a_irq_n);
  p_set_b_r5: assert property (@(posedge clk) disable iff (!srst_n)
    b_set |=> !b_irq_n);
  p_clr_b_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (b_clr && !b_set) |=> b_irq_n);
  p_hold_a_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!a_set && !a_clr) |=> $stable(a_irq_n));
  p_hold_b_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!b_set && !b_clr) |=> $stable(b_irq_n));
endmodule

bind mbox_dpram mbox_chk #(.AW(AW)) u_chk (
  .clk(clk), .srst_n(srst_n),
  .a_ce(a_ce), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr),
  .a_busy_n(a_busy_n), .a_irq_n(a_irq_n),
  .b_ce(b_ce), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr),
  .b_busy_n(b_busy_n), .b_irq_n(b_irq_n)
);

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BOX_B = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_A = BOX_B - 1'b1;

  logic clk = 1'b0;
  logic rst_n;
  logic a_ce, a_we, a_oe, a_busy_n, b_ce, b_we, b_oe, b_busy_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_irq_n, b_irq_n;

  always #10 clk = ~clk;

  mbox_dpram #(.AW(AW), .DW(DW)) i_mbox_dpram (
    .clk(clk), .rst_n(rst_n),
    .a_ce(a_ce), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_busy_n(a_busy_n), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_ce(b_ce), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_busy_n(b_busy_n), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] e_ard, e_brd;
  logic e_airq, e_birq;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic nxt_flag(logic cur, logic set, logic clr);
    if (set) return 1'b0;
    if (clr) return 1'b1;
    return cur;
  endfunction

  task automatic idle();
    a_ce = 0; a_we = 0; a_oe = 0; a_addr = '0; a_wdata = '0; a_busy_n = 1;
    b_ce = 0; b_we = 0; b_oe = 0; b_addr = '0; b_wdata = '0; b_busy_n = 1;
  endtask

  task automatic model_step();
    logic sa, ca, sb, cb;
    sa = b_ce && b_we && b_addr == BOX_A && b_busy_n;
    ca = a_ce && a_oe && a_addr == BOX_A && a_busy_n;
    sb = a_ce && a_we && a_addr == BOX_B && a_busy_n;
    cb = b_ce && b_oe && b_addr == BOX_B && b_busy_n;
    e_airq = nxt_flag(e_airq, sa, ca);
    e_birq = nxt_flag(e_birq, sb, cb);
    if (a_ce && a_oe && !a_we) e_ard = m_mem[a_addr];
    if (b_ce && b_oe && !b_we) e_brd = m_mem[b_addr];
    if (b_ce && b_we) m_mem[b_addr] = b_wdata;
    if (a_ce && a_we) m_mem[a_addr] = a_wdata;
  endtask

  task automatic step(string tag);
    model_step();
    @(negedge clk);
    chk(tag, "a_rdata", a_rdata, e_ard);
    chk(tag, "b_rdata", b_rdata, e_brd);
    chk(tag, "a_irq_n", {7'd0, a_irq_n}, {7'd0, e_airq});
    chk(tag, "b_irq_n", {7'd0, b_irq_n}, {7'd0, e_birq});
    idle();
  endtask

  task automatic wr_a(logic [AW-1:0] ad, logic [DW-1:0] d);
    a_ce = 1; a_we = 1; a_addr = ad; a_wdata = d;
  endtask
  task automatic wr_b(logic [AW-1:0] ad, logic [DW-1:0] d);
    b_ce = 1; b_we = 1; b_addr = ad; b_wdata = d;
  endtask
  task automatic rd_a(logic [AW-1:0] ad);
    a_ce = 1; a_oe = 1; a_addr = ad;
  endtask
  task automatic rd_b(logic [AW-1:0] ad);
    b_ce = 1; b_oe = 1; b_addr = ad;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    e_ard = '0; e_brd = '0; e_airq = 1; e_birq = 1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "a_irq_n", {7'd0, a_irq_n}, 8'd1);
    chk("R1", "b_irq_n", {7'd0, b_irq_n}, 8'd1);
    chk("R1", "a_rdata", a_rdata, '0);
    chk("R1", "b_rdata", b_rdata, '0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    step("R1");

    // R2: fill memory from port A (top word sets b irq, tracked by model)
    for (int i = 0; i < DEPTH; i++) begin
      wr_a(AW'(i), DW'(i * 7 + 3));
      step("R2");
    end
    rd_b(BOX_B); step("R6");
    rd_a(5); rd_b(9); step("R2");
    rd_a(20); rd_b(20); step("R2");
    a_ce = 1; a_oe = 0; a_addr = 30; step("R2");   // no oe: rdata holds

    // R5, R6, R7: port B mailbox
    wr_a(BOX_B, 8'h5A); step("R5");
    rd_b(BOX_B); step("R6");
    rd_a(BOX_B); step("R7");

    // R3, R4, R7: port A mailbox; clear with we=1
    wr_b(BOX_A, 8'hC3); step("R3");
    wr_a(BOX_A, 8'h11); a_oe = 1; step("R4");
    rd_b(BOX_A); step("R7");

    // R8: busy gating
    wr_b(BOX_A, 8'h22); b_busy_n = 0; step("R8");
    wr_b(BOX_A, 8'h23); step("R8");
    rd_a(BOX_A); a_busy_n = 0; step("R8");
    rd_a(BOX_A); step("R8");
    wr_a(BOX_B, 8'h44); a_busy_n = 0; step("R8");

    // R9: set and clear together
    wr_b(BOX_A, 8'h66); rd_a(BOX_A); step("R9");
    wr_a(BOX_B, 8'h77); rd_b(BOX_B); step("R9");
    wr_b(BOX_A, 8'h67); rd_a(BOX_A); b_busy_n = 0; step("R9");
    rd_a(BOX_A); rd_b(BOX_B); step("R9");

    // R10: write collisions
    wr_a(16, 8'hAA); wr_b(16, 8'hBB); step("R10");
    rd_a(16); step("R10");
    rd_a(17); wr_b(17, 8'h99); step("R10");
    rd_a(17); step("R10");

    // R11: own-box and plain writes
    wr_a(BOX_A, 8'h01); step("R11");
    wr_b(BOX_B, 8'h02); step("R11");
    wr_a(3, 8'h03); wr_b(4, 8'h04); step("R11");

    // random traffic biased to the mailbox words
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      a_ce = $urandom_range(0, 3) != 0; a_we = $urandom_range(0, 1);
      a_oe = $urandom_range(0, 3) != 0; a_busy_n = $urandom_range(0, 4) != 0;
      b_ce = $urandom_range(0, 3) != 0; b_we = $urandom_range(0, 1);
      b_oe = $urandom_range(0, 3) != 0; b_busy_n = $urandom_range(0, 4) != 0;
      a_addr = ($urandom_range(0, 1) != 0) ? AW'(DEPTH - 1 - $urandom_range(0, 3)) : AW'($urandom);
      b_addr = ($urandom_range(0, 1) != 0) ? AW'(DEPTH - 1 - $urandom_range(0, 3)) : AW'($urandom);
      a_wdata = DW'($urandom); b_wdata = DW'($urandom);
      step("R9");
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule